// File: doc/BRIEF.md
# Receive Channel DC Offset Calibrator

This block sits on one receive channel, directly behind that channel's digital low-pass filter. It holds a signed offset word and takes it off every filter result. Each corrected result is registered and appears on the output one clock after the filter presents it. A chip uses two copies of the block, one for the I channel and one for the Q channel.

The offset is learned through a calibration strobe. While the strobe is high, the stored offset is forced to zero. The first filter result that is accepted after the strobe falls becomes the new offset. Results keep flowing during and after calibration, with no gap in the output.

A counter measures how long the strobe stays high. If the strobe falls too early, a sticky warning flag is raised. A separate flag shows that a properly timed capture has completed. While the channel sleeps, filter results are ignored and the stored offset is held.

Top module: `rx_offset_cal`

## Requirements
- R1: After reset, `out_valid_o`, `cal_short_o` and `offset_valid_o` are 0. The stored offset is zero, so a result passes through unchanged.
- R2: While `cal_i` is high, the stored offset is zero. A result accepted in that time is output unchanged and is not captured.
- R3: The first result accepted with `cal_i` low after a high period is loaded as the new offset. That result is itself output with a zero offset. Later results do not change the offset.
- R4: A result accepted at clock edge k, meaning `flt_valid_i`=1 and `sleep_i`=0, appears at edge k. The output is `out_valid_o`=1 and `out_data_o` = `flt_data_i` minus the offset, both in two's complement. Otherwise `out_valid_o` is 0 after that edge.
- R5: The subtraction saturates. Results above +2^(W-1)-1 give +2^(W-1)-1, and results below -2^(W-1) give -2^(W-1).
- R6: When `cal_i` falls after having been sampled high for N edges, `cal_short_o` is set if N <= `MIN_HIGH_CYCLES` (default 608). It is cleared if N is larger. It is updated at the falling edge and holds otherwise.
- R7: `offset_valid_o` is 0 after any edge at which `cal_i` is high. It becomes 1 only when a capture follows a high period longer than `MIN_HIGH_CYCLES`.
- R8: While `sleep_i` is high, `flt_valid_i` is ignored. No output is produced, no capture happens, and the offset is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_i | input | 1 | Calibration strobe |
| sleep_i | input | 1 | Receive sleep request |
| flt_valid_i | input | 1 | Filter result strobe |
| flt_data_i | input | DATA_W | Filter result, two's complement |
| out_valid_o | output | 1 | Corrected result strobe |
| out_data_o | output | DATA_W | Corrected, saturated result |
| cal_short_o | output | 1 | Sticky flag: last strobe too short |
| offset_valid_o | output | 1 | A capture with a proper strobe completed |

## Verification
A wrong stored offset shows up on the very next accepted result as a constant error in `out_data_o`. It persists on every later result until the next calibration, so a single probe word after each capture exposes it. A miscounted strobe length shows up in `cal_short_o` one edge after the strobe falls, and in `offset_valid_o` at the capture edge. The bench therefore probes strobes of exactly 608 and 609 edges.

A wrongly armed capture state shows up as an offset that changes on a second result. This is checked by sending a repeated word that must come back as zero.

// File: rtl/rx_offset_pkg.sv
// Package: shared types for the receive offset calibrator.
// Assumes: nothing beyond standard SystemVerilog.
package rx_offset_pkg;
    // Phase of the calibration sequence
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,  // no capture pending
        PH_HIGH  = 2'd1,  // strobe high, counting
        PH_ARMED = 2'd2   // strobe low, waiting for first result
    } cal_phase_e;
endpackage

// File: rtl/roc_sat_sub.sv
// Module: roc_sat_sub
// Combinational two's complement a - b, clamped to the W-bit range.
// Assumes: both operands are signed W-bit values.
module roc_sat_sub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);
    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0] diff;

    // Widen by one bit, subtract, clamp when the top two bits disagree
    always_comb begin
        diff = {a_i[W-1], a_i} - {b_i[W-1], b_i};
        if (diff[W] != diff[W-1])
            y_o = diff[W] ? NEG_MIN : POS_MAX;
        else
            y_o = diff[W-1:0];
    end
endmodule

// File: rtl/roc_offset_store.sv
// Module: roc_offset_store
// Holds the channel's offset word: clear has priority over load.
// Assumes: clear_i and load_i come from the calibration controller.
module roc_offset_store #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] offset_o
);
    // Offset register: zero on reset or clear, captured on load, held otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)       offset_o <= '0;
        else if (clear_i) offset_o <= '0;
        else if (load_i)  offset_o <= data_i;
    end

    // R2: a clear request leaves the word at zero
    p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (offset_o == '0));

    // R8: without clear or load the word holds
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !load_i) |=> $stable(offset_o));
endmodule

// File: rtl/roc_cal_ctrl.sv
// Module: roc_cal_ctrl
// Times the calibration strobe, arms a one-shot capture after it falls,
// and keeps the short-strobe and offset-valid flags.
// Assumes: take_i is an accepted filter result (valid and not sleeping).
module roc_cal_ctrl
    import rx_offset_pkg::*;
#(
    parameter int MIN_HIGH_CYCLES = 608
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cal_i,
    input  logic take_i,
    output logic capture_o,
    output logic cal_short_o,
    output logic offset_valid_o
);
    localparam int CNT_W = $clog2(MIN_HIGH_CYCLES + 2);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MIN_HIGH_CYCLES);

    cal_phase_e       phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             long_q;
    logic             cnt_long;

    // Strobe counted past the minimum
    always_comb cnt_long = (cnt_q > LIMIT);

    // Capture the first accepted result once the strobe is low after a high phase
    always_comb capture_o = !cal_i && take_i &&
                            (phase_q == PH_HIGH || phase_q == PH_ARMED);

    // Phase, length counter and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q        <= PH_IDLE;
            cnt_q          <= '0;
            long_q         <= 1'b0;
            cal_short_o    <= 1'b0;
            offset_valid_o <= 1'b0;
        end else if (cal_i) begin
            if (phase_q != PH_HIGH) cnt_q <= CNT_W'(1);
            else if (!cnt_long)     cnt_q <= cnt_q + CNT_W'(1);
            phase_q        <= PH_HIGH;
            offset_valid_o <= 1'b0;
        end else if (phase_q == PH_HIGH) begin
            long_q      <= cnt_long;
            cal_short_o <= !cnt_long;
            if (capture_o) begin
                phase_q        <= PH_IDLE;
                offset_valid_o <= cnt_long;
            end else begin
                phase_q <= PH_ARMED;
            end
        end else if (capture_o) begin
            phase_q        <= PH_IDLE;
            offset_valid_o <= long_q;
        end
    end

    // R6: a fall at or before the limit raises the short flag
    p_short_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HIGH && !cal_i && !cnt_long) |=> cal_short_o);

    // R6: the flag changes only at a strobe fall
    p_short_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(phase_q == PH_HIGH && !cal_i) |=> $stable(cal_short_o));

    // R7: a high strobe drops the valid flag
    p_valid_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cal_i |=> !offset_valid_o);

    // R3: one capture per calibration
    p_one_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        capture_o |=> !capture_o || cal_i || phase_q == PH_IDLE);
endmodule

// File: rtl/rx_offset_cal.sv
// Module: rx_offset_cal (top)
// One receive channel: subtracts a calibrated DC offset from each filter
// result with saturation and registers the result for one cycle.
// Assumes: filter results are two's complement, one per flt_valid_i pulse.
module rx_offset_cal #(
    parameter int DATA_W          = 16,
    parameter int MIN_HIGH_CYCLES = 608
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_i,
    input  logic              sleep_i,
    input  logic              flt_valid_i,
    input  logic [DATA_W-1:0] flt_data_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] out_data_o,
    output logic              cal_short_o,
    output logic              offset_valid_o
);
    logic              take;
    logic              capture;
    logic [DATA_W-1:0] offset;
    logic [DATA_W-1:0] corrected;

    // Accepted result: valid and channel awake
    always_comb take = flt_valid_i && !sleep_i;

    roc_cal_ctrl #(.MIN_HIGH_CYCLES(MIN_HIGH_CYCLES)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cal_i          (cal_i),
        .take_i         (take),
        .capture_o      (capture),
        .cal_short_o    (cal_short_o),
        .offset_valid_o (offset_valid_o)
    );

    roc_offset_store #(.W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (cal_i),
        .load_i   (capture),
        .data_i   (flt_data_i),
        .offset_o (offset)
    );

    roc_sat_sub #(.W(DATA_W)) u_sub (
        .a_i (flt_data_i),
        .b_i (offset),
        .y_o (corrected)
    );

    // Output register for corrected results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            out_data_o  <= '0;
        end else begin
            out_valid_o <= take;
            if (take) out_data_o <= corrected;
        end
    end

    // R4: every accepted result yields an output next cycle
    p_out_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> out_valid_o);

    // R8: a sleeping channel produces nothing
    p_sleep_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> !out_valid_o);

    // R3: a capture happens only on a low strobe
    p_capture_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> !cal_i);
endmodule

// File: tb/test_rx_offset_cal.sv
module test_rx_offset_cal;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cal = 1'b0;
    logic          sleep = 1'b0;
    logic          fv = 1'b0;
    logic [W-1:0]  fd = '0;
    logic          ov;
    logic [W-1:0]  od;
    logic          cshort;
    logic          ovalid;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    rx_offset_cal #(.DATA_W(W), .MIN_HIGH_CYCLES(608)) i_rx_offset_cal (
        .clk(clk), .rst_n(rst_n), .cal_i(cal), .sleep_i(sleep),
        .flt_valid_i(fv), .flt_data_i(fd), .out_valid_o(ov), .out_data_o(od),
        .cal_short_o(cshort), .offset_valid_o(ovalid)
    );

    // Table for R4/R5 with offset +100 loaded: {input, expected}
    localparam logic [W-1:0] TBL [6][2] = '{
        '{16'sd500,    16'sd400},
        '{16'sd0,      -16'sd100},
        '{16'sd32767,  16'sd32667},
        '{-16'sd32700, -16'sd32768},
        '{-16'sd32768, -16'sd32768},
        '{-16'sd32668, -16'sd32768}
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(exp));
        end
    endtask

    // Present one result; afterwards (at a negedge) the registered output is visible
    task automatic send(input logic [W-1:0] d);
        @(negedge clk); fv = 1'b1; fd = d;
        @(negedge clk); fv = 1'b0;
    endtask

    task automatic send_chk(input string req, input logic [W-1:0] d, input logic [W-1:0] exp);
        send(d);
        check({req, " valid"}, {15'd0, ov}, 16'd1);
        check(req, od, exp);
    endtask

    // Hold the strobe high for n edges
    task automatic cal_pulse(input int n);
        @(negedge clk); cal = 1'b1;
        repeat (n) @(negedge clk);
        cal = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 out_valid", {15'd0, ov}, 16'd0);
        check("R1 cal_short", {15'd0, cshort}, 16'd0);
        check("R1 offset_valid", {15'd0, ovalid}, 16'd0);
        send_chk("R1 passthrough", 16'sd1234, 16'sd1234);

        // R2: result during strobe high passes unchanged and is not captured
        @(negedge clk); cal = 1'b1;
        repeat (5) @(negedge clk);
        check("R7 valid low during cal", {15'd0, ovalid}, 16'd0);
        send_chk("R2 during cal", 16'sd777, 16'sd777);
        repeat (620) @(negedge clk);
        cal = 1'b0;
        @(negedge clk);
        check("R6 long clears short", {15'd0, cshort}, 16'd0);
        // R3: first result after fall captured, output raw
        send_chk("R3 capture raw", 16'sd100, 16'sd100);
        check("R7 valid after long", {15'd0, ovalid}, 16'd1);
        send_chk("R3 second not loaded", 16'sd100, 16'sd0);

        // R4/R5 table walk, offset = 100
        for (int i = 0; i < 6; i++)
            send_chk("R4/R5 table", TBL[i][0], TBL[i][1]);

        // R6/R7: exactly 608 edges is too short
        cal_pulse(608);
        @(negedge clk);
        check("R6 short at 608", {15'd0, cshort}, 16'd1);
        send_chk("R3 capture short", 16'sd300, 16'sd300);
        check("R7 no valid after short", {15'd0, ovalid}, 16'd0);
        send_chk("R3 offset 300", 16'sd300, 16'sd0);
        repeat (3) @(negedge clk);
        check("R6 sticky", {15'd0, cshort}, 16'd1);

        // 609 edges is long enough; load -50
        cal_pulse(609);
        @(negedge clk);
        check("R6 609 clears short", {15'd0, cshort}, 16'd0);
        send_chk("R3 capture neg", -16'sd50, -16'sd50);
        check("R7 valid after 609", {15'd0, ovalid}, 16'd1);
        send_chk("R5 positive clamp", 16'sd32767, 16'sd32767);

        // R8: sleep ignores results and keeps offset
        @(negedge clk); sleep = 1'b1;
        send(16'sd1000);
        check("R8 no output asleep", {15'd0, ov}, 16'd0);
        @(negedge clk); sleep = 1'b0;
        send_chk("R8 offset kept", 16'sd1000, 16'sd1050);

        // R1 again after mid-run reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 valid after reset", {15'd0, ovalid}, 16'd0);
        send_chk("R1 offset zero", 16'sd42, 16'sd42);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule